// File: doc/BRIEF.md
# SDRAM Read Data Return Pipeline

This block is the read-return datapath of a synchronous DRAM. The array side supplies one column word per clock, together with a valid strobe. The block holds each word for the programmed read latency and then drives it onto a 16-bit data bus. It also drives one output enable for each byte lane, which stands for the lane's high-impedance control at the pad. The read latency is chosen at run time, either 2 or 3 cycles. A new word may arrive on every clock, so reads can follow one another with no idle gap between them.

Two events take data off the bus. A per-lane mask bit blanks its lane two cycles after it is sampled, whatever the latency setting. A precharge or burst-stop event cancels the word sampled on the same edge. Because of this, the bus goes to high impedance exactly one read latency after the event, while words already in flight still come out.

Every input is sampled on the rising clock edge. Every output is a register updated on that edge. Reset is synchronous and active high.

Top module: `sdr_rdout_pipe`

## Requirements
- R1: While reset is high, and in the first cycle after it, `dq_vld_o` is 0, `dq_oe_o` is 2'b00 and `dq_o` is 0.
- R2: With `lat_i` = 2, a word sampled with `rd_vld_i` = 1 at edge k is driven after edge k+1. It is therefore seen on `dq_o` with `dq_vld_o` = 1 at edge k+2, and for that one cycle only.
- R3: With `lat_i` = 3, a word sampled at edge k is driven after edge k+2. It is therefore seen at edge k+3, for one cycle.
- R4: Words sampled on consecutive edges leave on consecutive cycles, in arrival order, with no gap and no repeat, at either latency.
- R5: `dq_mask_i[1]` (upper lane, bits 15:8) sampled high at edge m clears `dq_oe_o[1]` and forces `dq_o[15:8]` to 0 in the cycle seen at edge m+2. This holds at both latencies. `dq_vld_o` and the lower lane are not affected.
- R6: `dq_mask_i[0]` (lower lane, bits 7:0) does the same for `dq_oe_o[0]` and `dq_o[7:0]`, and leaves the upper lane as it is.
- R7: `trunc_i` sampled high at edge p removes the word sampled at edge p. In the cycle seen at edge p+L (L = `lat_i`), `dq_vld_o` and `dq_oe_o` are 0. Words sampled before edge p, and after it, come out normally.
- R8: In any cycle with no word in the output stage, `dq_vld_o` = 0, `dq_oe_o` = 0 and `dq_o` = 0.
- R9: `lat_i` may change only while no word is in flight. The new value governs the next word sampled.
- R10: `dq_oe_o[i]` is high only when `dq_vld_o` is high, and `dq_o` lane i carries the word only when `dq_oe_o[i]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_vld_i | input | 1 | A column word is present on `rd_data_i` |
| rd_data_i | input | 16 | Column word from the array |
| dq_mask_i | input | 2 | Per-lane output mask, bit 1 upper byte, bit 0 lower byte |
| trunc_i | input | 1 | Precharge or burst-stop event |
| lat_i | input | 2 | Read latency in cycles, binary 2 or 3 |
| dq_o | output | 16 | Read data bus |
| dq_oe_o | output | 2 | Per-lane output enable, bit 1 upper byte |
| dq_vld_o | output | 1 | A read word occupies the output stage |

## Verification
The assertions assume three things about the inputs. `lat_i` only ever holds 2 or 3. It changes only on a cycle where the delay stages hold no word. Reset is held for at least one edge before any check counts. The stimulus keeps to these rules in two ways. Each scenario sets the latency at the start of its run, before any word is driven. Each run ends with several idle cycles, which drain the pipeline before the next scenario may change the setting. Mask and truncation events are driven freely, on any cycle and at either latency, because the design must accept them at all times.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
  localparam int unsigned RD_DW      = 16;
  localparam int unsigned RD_LANE_W  = 8;
  localparam int unsigned RD_MIN_LAT = 2;
  localparam int unsigned RD_MAX_LAT = 3;

  // stage index in the delay line that feeds the output register
  function automatic int unsigned tap_of(input int unsigned lat);
    return lat - RD_MIN_LAT;
  endfunction
endpackage

// File: rtl/sdr_rd_delay.sv
module sdr_rd_delay
  import sdr_rd_pkg::*;
#(
  parameter int unsigned DW      = RD_DW,
  parameter int unsigned MAX_LAT = RD_MAX_LAT,
  parameter int unsigned LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [DW-1:0]    in_data,
  input  logic             kill,
  input  logic [LAT_W-1:0] lat,
  output logic             sel_vld,
  output logic [DW-1:0]    sel_data,
  output logic             busy
);
  localparam int unsigned DEPTH = MAX_LAT - RD_MIN_LAT + 1;

  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    dat_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) vld_q[g] <= 1'b0;
          else     vld_q[g] <= in_vld & ~kill;
          dat_q[g] <= in_data;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) vld_q[g] <= 1'b0;
          else     vld_q[g] <= vld_q[g-1];
          dat_q[g] <= dat_q[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    sel_vld  = 1'b0;
    sel_data = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (tap_of(int'(lat)) == s) begin
        sel_vld  = vld_q[s];
        sel_data = dat_q[s];
      end
    end
  end

  assign busy = |vld_q;

  // R9
  lat_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(lat) >= RD_MIN_LAT) && (int'(lat) <= MAX_LAT));

  // R9
  lat_change_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (lat != $past(lat)) |-> !busy);
endmodule

// File: rtl/sdr_rd_lane.sv
module sdr_rd_lane #(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mask_i,
  input  logic          word_vld_i,
  input  logic [LW-1:0] word_i,
  output logic          oe_o,
  output logic [LW-1:0] dq_o
);
  logic          mask_q;
  logic          oe_q;
  logic [LW-1:0] dq_q;
  logic          drive;

  assign drive = word_vld_i & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b0;
      oe_q   <= 1'b0;
      dq_q   <= '0;
    end else begin
      mask_q <= mask_i;
      oe_q   <= drive;
      dq_q   <= drive ? word_i : '0;
    end
  end

  assign oe_o = oe_q;
  assign dq_o = dq_q;

  logic [1:0] settle_q;
  always_ff @(posedge clk) begin
    if (rst)                 settle_q <= 2'd0;
    else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
  end

  // R5
  mask_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (settle_q >= 2'd2 && $past(mask_i, 2)) |-> !oe_q);

  // R10
  oe_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
    (settle_q >= 2'd1 && oe_q) |-> $past(word_vld_i));
endmodule

// File: rtl/sdr_rdout_pipe.sv
module sdr_rdout_pipe
  import sdr_rd_pkg::*;
#(
  parameter int unsigned DW      = RD_DW,
  parameter int unsigned LANE_W  = RD_LANE_W,
  parameter int unsigned MAX_LAT = RD_MAX_LAT,
  parameter int unsigned LANES   = DW / LANE_W,
  parameter int unsigned LAT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_vld_i,
  input  logic [DW-1:0]    rd_data_i,
  input  logic [LANES-1:0] dq_mask_i,
  input  logic             trunc_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [DW-1:0]    dq_o,
  output logic [LANES-1:0] dq_oe_o,
  output logic             dq_vld_o
);
  logic          sel_vld;
  logic [DW-1:0] sel_data;
  logic          busy;
  logic          vld_q;

  sdr_rd_delay #(.DW(DW), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_delay (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (rd_vld_i),
    .in_data  (rd_data_i),
    .kill     (trunc_i),
    .lat      (lat_i),
    .sel_vld  (sel_vld),
    .sel_data (sel_data),
    .busy     (busy)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      sdr_rd_lane #(.LW(LANE_W)) u_lane (
        .clk        (clk),
        .rst        (rst),
        .mask_i     (dq_mask_i[g]),
        .word_vld_i (sel_vld),
        .word_i     (sel_data[g*LANE_W +: LANE_W]),
        .oe_o       (dq_oe_o[g]),
        .dq_o       (dq_o[g*LANE_W +: LANE_W])
      );

      // R10
      oe_implies_vld_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe_o[g] |-> dq_vld_o);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= sel_vld;
  end
  assign dq_vld_o = vld_q;

  logic [1:0] settle_q;
  always_ff @(posedge clk) begin
    if (rst)                   settle_q <= 2'd0;
    else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
  end

  // R2 R7
  lat2_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (settle_q >= 2'd2 && int'($past(lat_i)) == 2)
      |-> (dq_vld_o == $past(rd_vld_i && !trunc_i, 2)));

  // R3 R7
  lat3_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (settle_q == 2'd3 && int'($past(lat_i)) == 3)
      |-> (dq_vld_o == $past(rd_vld_i && !trunc_i, 3)));

  // R2
  lat2_data_chk: assert property (@(posedge clk) disable iff (rst)
    (settle_q >= 2'd2 && int'($past(lat_i)) == 2 && (&dq_oe_o))
      |-> (dq_o == $past(rd_data_i, 2)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!dq_vld_o && dq_oe_o == '0));
endmodule

// File: tb/tb_sdr_rdout_pipe.sv
module tb_sdr_rdout_pipe;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAXN = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        rd_vld_i;
  logic [15:0] rd_data_i;
  logic [1:0]  dq_mask_i;
  logic        trunc_i;
  logic [1:0]  lat_i;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe_o;
  logic        dq_vld_o;

  int checks = 0;
  int errors = 0;

  logic        v_vld [MAXN];
  logic [15:0] v_dat [MAXN];
  logic [1:0]  v_msk [MAXN];
  logic        v_trn [MAXN];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_rdout_pipe dut (
    .clk(clk), .rst(rst), .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i),
    .dq_mask_i(dq_mask_i), .trunc_i(trunc_i), .lat_i(lat_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_vld_o(dq_vld_o)
  );

  task automatic check_out(string req, logic ev, logic [1:0] eoe, logic [15:0] edq);
    checks++;
    if (dq_vld_o !== ev || dq_oe_o !== eoe || dq_o !== edq) begin
      errors++;
      $display("FAIL %s: vld=%b oe=%b dq=%h expected vld=%b oe=%b dq=%h",
               req, dq_vld_o, dq_oe_o, dq_o, ev, eoe, edq);
    end
  endtask

  task automatic clear_vec();
    for (int i = 0; i < MAXN; i++) begin
      v_vld[i] = 1'b0; v_dat[i] = '0; v_msk[i] = '0; v_trn[i] = 1'b0;
    end
  endtask

  // called at a falling edge; drives n cycles of stimulus and checks every cycle
  task automatic run_seq(int n, int lat, string req);
    lat_i = 2'(lat);
    for (int i = 0; i < n + 5; i++) begin
      rd_vld_i  = (i < n) ? v_vld[i] : 1'b0;
      rd_data_i = (i < n) ? v_dat[i] : 16'h0;
      dq_mask_i = (i < n) ? v_msk[i] : 2'b00;
      trunc_i   = (i < n) ? v_trn[i] : 1'b0;
      @(posedge clk);
      @(negedge clk);
      begin
        int src = i - lat + 1;
        logic       ev;
        logic [1:0] m;
        logic [1:0] eoe;
        logic [15:0] edq;
        ev  = (src >= 0 && src < n) ? (v_vld[src] && !v_trn[src]) : 1'b0;
        m   = (i >= 1 && i - 1 < n) ? v_msk[i-1] : 2'b00;
        eoe = {ev & ~m[1], ev & ~m[0]};
        edq = ev ? {eoe[1] ? v_dat[src][15:8] : 8'h0, eoe[0] ? v_dat[src][7:0] : 8'h0} : 16'h0;
        check_out(req, ev, eoe, edq);
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; rd_vld_i = 1'b1; rd_data_i = 16'hFFFF; dq_mask_i = 2'b00;
    trunc_i = 1'b0; lat_i = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out("R1 during reset", 1'b0, 2'b00, 16'h0);
    rd_vld_i = 1'b0;
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check_out("R1 after reset", 1'b0, 2'b00, 16'h0);
  endtask

  task automatic t_single(int lat, string req);
    clear_vec();
    v_vld[0] = 1'b1; v_dat[0] = 16'hA5C3 + 16'(lat);
    run_seq(1, lat, req);
  endtask

  // R4 back-to-back words
  task automatic t_b2b(int lat);
    clear_vec();
    for (int i = 0; i < 8; i++) begin
      v_vld[i] = 1'b1; v_dat[i] = 16'h1100 * 16'(i + 1) + 16'(lat);
    end
    run_seq(8, lat, lat == 2 ? "R4 lat2" : "R4 lat3");
  endtask

  // R5 R6 lane masks
  task automatic t_mask(int lat);
    clear_vec();
    for (int i = 0; i < 8; i++) begin
      v_vld[i] = 1'b1; v_dat[i] = 16'h3C00 + 16'(i * 17);
    end
    v_msk[1] = 2'b10; v_msk[2] = 2'b10; v_msk[4] = 2'b01; v_msk[6] = 2'b11;
    run_seq(8, lat, "R5 R6 mask");
  endtask

  // R7 truncation
  task automatic t_trunc(int lat);
    clear_vec();
    for (int i = 0; i < 8; i++) begin
      v_vld[i] = (i != 6); v_dat[i] = 16'hBE00 + 16'(i);
    end
    v_trn[3] = 1'b1; v_trn[6] = 1'b1;
    run_seq(8, lat, "R7 trunc");
  endtask

  // R8 idle with masks toggling
  task automatic t_idle();
    clear_vec();
    for (int i = 0; i < 6; i++) begin
      v_msk[i] = 2'(i); v_dat[i] = 16'hFFFF;
    end
    run_seq(6, 2, "R8 idle");
  endtask

  // R9 latency change between drained bursts
  task automatic t_latchange();
    clear_vec();
    v_vld[0] = 1'b1; v_dat[0] = 16'h7E01; v_vld[1] = 1'b1; v_dat[1] = 16'h7E02;
    run_seq(2, 3, "R9 to lat3");
    run_seq(2, 2, "R9 to lat2");
    run_seq(2, 3, "R9 back to lat3");
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_single(2, "R2 single");
    t_single(3, "R3 single");
    t_b2b(2);
    t_b2b(3);
    t_mask(2);
    t_mask(3);
    t_trunc(2);
    t_trunc(3);
    t_idle();
    t_latchange();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule